// File: doc/BRIEF.md
# Dual-Master Channel Access Arbiter

This block decides who owns a shared auxiliary channel: a host software master or an embedded microcontroller. Software asks for the channel with a one-cycle write pulse and gives it back with a separate one-cycle done pulse. The microcontroller holds a level request for as long as it wants the channel. Ownership is reported as a two-bit coded field, not as separate grant lines. Software finds out whether its request succeeded by reading the field back and looking for the software code.

When software wins the channel while the channel is disabled, the block first brings the channel up. It raises enable and reset together. It then waits for the channel's reset-done input to rise, drops reset, and waits for reset-done to fall. Only after that does it hand ownership to software. Each wait has a bounded window of POLL_LIMIT polls spaced POLL_PERIOD clocks apart. If a window runs out, the block returns to idle, disables the channel and sets a sticky error flag. If the channel is already enabled, the request is granted directly.

The state machine has five states:
- ST_IDLE: nobody owns the channel.
- ST_RST_HI: reset is asserted and the block waits for reset-done to go high.
- ST_RST_LO: reset is released and the block waits for reset-done to go low.
- ST_SW: software owns the channel.
- ST_MCU: the microcontroller owns the channel.

The transitions are:
- IDLE→MCU on a microcontroller request.
- IDLE→SW on a software request while the channel is enabled.
- IDLE→RST_HI on a software request while the channel is disabled.
- RST_HI→RST_LO when reset-done is seen high.
- RST_LO→SW when reset-done is seen low.
- RST_HI→IDLE or RST_LO→IDLE when the window expires.
- SW→IDLE on a done pulse.
- MCU→IDLE when the microcontroller request drops.

Top module: `chan_arb_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, owner_status is 0 and chan_enable, chan_reset and seq_error are all 0.
- R2: owner_status encodes the owner as follows: 0 means idle (this includes the enable/reset sequence), 1 means software and 2 means the microcontroller. The value 3 never appears.
- R3: In ST_IDLE, a high mcu_req sets owner_status to 2 on the next clock. If sw_req_wr is pulsed in the same cycle, the microcontroller wins and the software pulse is discarded.
- R4: While owner_status is 2, a sw_req_wr pulse has no effect and owner_status stays 2. When mcu_req drops, owner_status returns to 0 on the next clock.
- R5: A sw_req_wr pulse in ST_IDLE with chan_enable at 1 and mcu_req low sets owner_status to 1 on the next clock, and chan_reset stays 0.
- R6: A sw_req_wr pulse in ST_IDLE with chan_enable at 0 and mcu_req low raises chan_enable and chan_reset together on the next clock, while owner_status stays 0.
- R7: While chan_reset is 1, a high chan_rst_done clears chan_reset on the next clock. After that, a low chan_rst_done sets owner_status to 1 on the next clock.
- R8: Each reset-done wait lasts at most POLL_LIMIT*POLL_PERIOD cycles (44 with the defaults). If the awaited level has not appeared by then, the next clock gives owner_status 0, chan_enable 0 and chan_reset 0, and sets seq_error. seq_error then stays 1 until rst_n is low.
- R9: A sw_done_wr pulse while owner_status is 1 returns owner_status to 0 on the next clock. In every other state, sw_done_wr has no effect.
- R10: mcu_req has no effect while the enable/reset sequence runs. The sequence completes for software, or times out, as if mcu_req were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_wr | input | 1 | One-cycle pulse: software writes 1 to its request bit |
| sw_done_wr | input | 1 | One-cycle pulse: software writes 1 to its done bit |
| mcu_req | input | 1 | Microcontroller request level; dropping it releases the channel |
| chan_rst_done | input | 1 | Reset-done status from the channel |
| owner_status | output | 2 | Ownership code: 0 idle, 1 software, 2 microcontroller |
| chan_enable | output | 1 | Channel enable |
| chan_reset | output | 1 | Channel reset |
| seq_error | output | 1 | Sticky flag: a reset-done wait timed out |

## Verification
The assertions assume the following about the inputs: sw_req_wr and sw_done_wr are synchronous pulses, mcu_req is a synchronous level, and chan_rst_done may change in any cycle, whether or not reset is asserted. The bench drives every input at the falling clock edge. It drives chan_rst_done from a responder that follows chan_reset after a random delay, and it sometimes chooses a delay longer than the window so that timeouts occur. Occasional mid-run resets disable the channel again, so the enable/reset sequence is exercised repeatedly, both with and without a competing microcontroller request.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HI,
        ST_RST_LO,
        ST_SW,
        ST_MCU
    } arb_state_e;

    localparam logic [1:0] OWN_IDLE = 2'd0;
    localparam logic [1:0] OWN_SW   = 2'd1;
    localparam logic [1:0] OWN_MCU  = 2'd2;

endpackage

// File: rtl/chan_arb_poll_timer.sv
module chan_arb_poll_timer #(
    parameter int POLL_LIMIT  = 11,
    parameter int POLL_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int WINDOW = POLL_LIMIT * POLL_PERIOD;
    localparam int CW     = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;

    // Counts the cycles spent in one wait; restarts whenever the wait changes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/chan_arb_fsm.sv
module chan_arb_fsm
    import chan_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req_wr,
    input  logic       sw_done_wr,
    input  logic       mcu_req,
    input  logic       chan_rst_done,
    input  logic       enabled,
    input  logic       expired,
    output arb_state_e state_q,
    output logic       start_seq,
    output logic       seq_timeout,
    output logic       wait_clear,
    output logic       timer_run
);
    arb_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mcu_req) begin
                    state_d = ST_MCU;
                end else if (sw_req_wr) begin
                    state_d = enabled ? ST_SW : ST_RST_HI;
                end
            end
            ST_RST_HI: begin
                if (chan_rst_done) begin
                    state_d = ST_RST_LO;
                end else if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RST_LO: begin
                if (!chan_rst_done) begin
                    state_d = ST_SW;
                end else if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SW: begin
                if (sw_done_wr) begin
                    state_d = ST_IDLE;
                end
            end
            ST_MCU: begin
                if (!mcu_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Transition-event outputs.
    always_comb begin
        start_seq   = 1'b0;
        seq_timeout = 1'b0;
        wait_clear  = 1'b0;
        timer_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_seq = !mcu_req && sw_req_wr && !enabled;
            end
            ST_RST_HI: begin
                timer_run   = 1'b1;
                wait_clear  = chan_rst_done;
                seq_timeout = !chan_rst_done && expired;
            end
            ST_RST_LO: begin
                timer_run   = 1'b1;
                seq_timeout = chan_rst_done && expired;
            end
            ST_SW, ST_MCU: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/chan_arb_status.sv
module chan_arb_status
    import chan_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  arb_state_e state_q,
    input  logic       start_seq,
    input  logic       seq_timeout,
    output logic [1:0] owner_status,
    output logic       chan_enable,
    output logic       chan_reset,
    output logic       seq_error
);
    // The enable register and the sticky error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_enable <= 1'b0;
            seq_error   <= 1'b0;
        end else begin
            if (start_seq) begin
                chan_enable <= 1'b1;
            end else if (seq_timeout) begin
                chan_enable <= 1'b0;
            end
            if (seq_timeout) begin
                seq_error <= 1'b1;
            end
        end
    end

    // Decode the state into the ownership code and the reset line.
    always_comb begin
        owner_status = OWN_IDLE;
        chan_reset   = 1'b0;
        unique case (state_q)
            ST_IDLE:   owner_status = OWN_IDLE;
            ST_RST_HI: chan_reset   = 1'b1;
            ST_RST_LO: owner_status = OWN_IDLE;
            ST_SW:     owner_status = OWN_SW;
            ST_MCU:    owner_status = OWN_MCU;
            default:   owner_status = OWN_IDLE;
        endcase
    end

endmodule

// File: rtl/chan_arb_top.sv
module chan_arb_top
    import chan_arb_pkg::*;
#(
    parameter int POLL_LIMIT  = 11,
    parameter int POLL_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req_wr,
    input  logic       sw_done_wr,
    input  logic       mcu_req,
    input  logic       chan_rst_done,
    output logic [1:0] owner_status,
    output logic       chan_enable,
    output logic       chan_reset,
    output logic       seq_error
);
    arb_state_e state_q;
    logic       start_seq;
    logic       seq_timeout;
    logic       wait_clear;
    logic       timer_run;
    logic       expired;

    chan_arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_req_wr    (sw_req_wr),
        .sw_done_wr   (sw_done_wr),
        .mcu_req      (mcu_req),
        .chan_rst_done(chan_rst_done),
        .enabled      (chan_enable),
        .expired      (expired),
        .state_q      (state_q),
        .start_seq    (start_seq),
        .seq_timeout  (seq_timeout),
        .wait_clear   (wait_clear),
        .timer_run    (timer_run)
    );

    chan_arb_poll_timer #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_PERIOD(POLL_PERIOD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .clear  (wait_clear),
        .expired(expired)
    );

    chan_arb_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .start_seq   (start_seq),
        .seq_timeout (seq_timeout),
        .owner_status(owner_status),
        .chan_enable (chan_enable),
        .chan_reset  (chan_reset),
        .seq_error   (seq_error)
    );

endmodule

// File: rtl/chan_arb_checker.sv
module chan_arb_checker
    import chan_arb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sw_req_wr,
    input logic       sw_done_wr,
    input logic       mcu_req,
    input logic       chan_rst_done,
    input logic [1:0] owner_status,
    input logic       chan_enable,
    input logic       chan_reset,
    input logic       seq_error,
    input arb_state_e state_q
);
    // R2: the code 3 is never produced.
    a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        owner_status != 2'd3);

    // R3: the microcontroller wins from idle.
    a_r3_mcu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mcu_req) |=> owner_status == OWN_MCU);

    // R4: no software grant straight out of microcontroller ownership.
    a_r4_no_sw_from_mcu: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_status == OWN_MCU) |=> owner_status != OWN_SW);

    // R6: reset only ever rises together with a rising enable.
    a_r6_enable_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_reset) |-> $rose(chan_enable));

    // R7: reset-done seen high releases the reset.
    a_r7_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_reset && chan_rst_done) |=> !chan_reset);

    // R8: the error flag is sticky.
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> seq_error);

    // R9: a done pulse releases software ownership.
    a_r9_sw_release: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_status == OWN_SW && sw_done_wr) |=> owner_status == OWN_IDLE);

endmodule

bind chan_arb_top chan_arb_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req_wr    (sw_req_wr),
    .sw_done_wr   (sw_done_wr),
    .mcu_req      (mcu_req),
    .chan_rst_done(chan_rst_done),
    .owner_status (owner_status),
    .chan_enable  (chan_enable),
    .chan_reset   (chan_reset),
    .seq_error    (seq_error),
    .state_q      (state_q)
);

// File: tb/tb_chan_arb_top.sv
`timescale 1ns/1ps
module tb_chan_arb_top;
    localparam int PL  = 11;
    localparam int PP  = 4;
    localparam int WIN = PL * PP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_req_wr = 1'b0;
    logic       sw_done_wr = 1'b0;
    logic       mcu_req = 1'b0;
    logic       chan_rst_done = 1'b0;
    logic [1:0] owner_status;
    logic       chan_enable;
    logic       chan_reset;
    logic       seq_error;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chan_arb_top #(.POLL_LIMIT(PL), .POLL_PERIOD(PP)) dut (
        .clk(clk), .rst_n(rst_n), .sw_req_wr(sw_req_wr), .sw_done_wr(sw_done_wr),
        .mcu_req(mcu_req), .chan_rst_done(chan_rst_done), .owner_status(owner_status),
        .chan_enable(chan_enable), .chan_reset(chan_reset), .seq_error(seq_error)
    );

    // Bench model: 0 idle, 1 wait-high, 2 wait-low, 3 software, 4 microcontroller.
    int    m_st = 0;
    int    m_cnt = 0;
    bit    m_en = 1'b0;
    bit    m_err = 1'b0;
    string m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_en <= 1'b0; m_err <= 1'b0; m_tag <= "R1";
        end else begin
            case (m_st)
                0: if (mcu_req) begin m_st <= 4; m_tag <= "R3"; end
                   else if (sw_req_wr && m_en) begin m_st <= 3; m_tag <= "R5"; end
                   else if (sw_req_wr) begin m_st <= 1; m_en <= 1'b1; m_cnt <= 0; m_tag <= "R6"; end
                1: if (chan_rst_done) begin m_st <= 2; m_cnt <= 0; m_tag <= "R7"; end
                   else if (m_cnt == WIN - 1) begin m_st <= 0; m_en <= 1'b0; m_err <= 1'b1; m_tag <= "R8"; end
                   else begin m_cnt <= m_cnt + 1; m_tag <= "R10"; end
                2: if (!chan_rst_done) begin m_st <= 3; m_tag <= "R7"; end
                   else if (m_cnt == WIN - 1) begin m_st <= 0; m_en <= 1'b0; m_err <= 1'b1; m_tag <= "R8"; end
                   else begin m_cnt <= m_cnt + 1; m_tag <= "R10"; end
                3: if (sw_done_wr) begin m_st <= 0; m_tag <= "R9"; end
                4: if (!mcu_req) begin m_st <= 0; m_tag <= "R4"; end
                default: m_st <= 0;
            endcase
        end
    end

    function automatic int exp_status(int st);
        return (st == 3) ? 1 : (st == 4) ? 2 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Responder: follows chan_reset after a delay; a huge delay never answers.
    int resp_delay = 2;
    int resp_cnt = 0;

    task automatic respond();
        if (chan_reset != chan_rst_done) begin
            if (resp_cnt >= resp_delay) begin
                chan_rst_done = chan_reset;
                resp_cnt = 0;
            end else begin
                resp_cnt++;
            end
        end else begin
            resp_cnt = 0;
        end
    endtask

    // Falling edge: compare every output with the model, then run the responder.
    task automatic tick();
        @(negedge clk);
        chk(m_tag, "owner_status", int'(owner_status), exp_status(m_st));
        chk(m_tag, "chan_reset", int'(chan_reset), (m_st == 1) ? 1 : 0);
        chk(m_tag, "chan_enable", int'(chan_enable), int'(m_en));
        chk(m_tag, "seq_error", int'(seq_error), int'(m_err));
        respond();
    endtask

    task automatic pulse_req();
        sw_req_wr = 1'b1; tick(); sw_req_wr = 1'b0;
    endtask

    task automatic pulse_done();
        sw_done_wr = 1'b1; tick(); sw_done_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(); tick();
        chk("R1", "status in reset", int'(owner_status), 0);
        chk("R1", "enable in reset", int'(chan_enable), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "status after reset", int'(owner_status), 0);
        chk("R1", "error after reset", int'(seq_error), 0);

        // R3: a tie from idle goes to the microcontroller.
        mcu_req = 1'b1; sw_req_wr = 1'b1; tick(); sw_req_wr = 1'b0;
        chk("R3", "tie winner", int'(owner_status), 2);
        // R4: a software request is refused while the microcontroller owns the channel.
        pulse_req();
        chk("R4", "refused request", int'(owner_status), 2);
        mcu_req = 1'b0; tick();
        chk("R4", "mcu release", int'(owner_status), 0);
        // R6: from disabled, enable and reset rise together.
        pulse_req();
        chk("R6", "reset raised", int'(chan_reset), 1);
        chk("R6", "enable raised", int'(chan_enable), 1);
        chk("R6", "status during seq", int'(owner_status), 0);
        // R10: a microcontroller request during the sequence is ignored.
        mcu_req = 1'b1;
        repeat (12) tick();
        chk("R7", "granted after seq", int'(owner_status), 1);
        mcu_req = 1'b0;
        tick();
        // R9: a done pulse releases the channel.
        pulse_done();
        chk("R9", "sw release", int'(owner_status), 0);
        pulse_done();
        chk("R9", "done ignored in idle", int'(owner_status), 0);
        // R5: already enabled, so the request is granted directly.
        pulse_req();
        chk("R5", "direct grant", int'(owner_status), 1);
        chk("R5", "no reset pulse", int'(chan_reset), 0);
        pulse_done();

        // R8: reset-done never rises, so the wait times out.
        do_reset();
        resp_delay = 1000000;
        pulse_req();
        repeat (WIN - 1) tick();
        chk("R8", "reset held before timeout", int'(chan_reset), 1);
        tick();
        chk("R8", "reset dropped at timeout", int'(chan_reset), 0);
        chk("R8", "enable dropped", int'(chan_enable), 0);
        chk("R8", "error set", int'(seq_error), 1);
        repeat (5) tick();
        chk("R8", "error sticky", int'(seq_error), 1);
        resp_delay = 2;
        repeat (3) tick();

        // Random phase.
        for (int i = 0; i < 30000; i++) begin
            if ($urandom % 500 == 0) begin
                rst_n = 1'b0;
            end else begin
                rst_n = 1'b1;
            end
            sw_req_wr  = ($urandom % 6 == 0);
            sw_done_wr = ($urandom % 5 == 0);
            if ($urandom % 12 == 0) mcu_req = ~mcu_req;
            if (chan_reset != chan_rst_done && resp_cnt == 0)
                resp_delay = ($urandom % 7 == 0) ? WIN + 10 : int'($urandom % 10);
            tick();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule